// File: doc/BRIEF.md
# Threshold programming command detector

This block watches an already decoded two-wire write stream (start and stop events, plus one strobe for each acknowledged byte) together with a digital flag. The flag is high while the high programming voltage is present on the write-protect pin. Most frames are ordinary memory writes and pass by untouched. A few frames carry a reserved byte pattern, and the flag qualifies them. Those frames are turned into nonvolatile operations on a model of the supply trip-threshold cell. One operation raises the stored threshold to the present supply code. The other drops it to a fixed floor.

A qualifying frame has an effect only when its closing stop arrives. At that stop the block pulses a set or clear request to the cell. It also holds a write-block output high, so the normal memory-write path does not act on the frame. It then stays busy until the programming flag is removed, and ignores all bus traffic while busy. A frame that loses its qualification anywhere on the way is discarded. The block takes no action on it, and it is left to the normal path.

Top module: `trip_prog_detect`

## Requirements
- R1: After reset, `trip_code` equals `DEFAULT_CODE` (20 by default), and `prog_busy`, `prog_done`, `set_req`, `clr_req` and `nvm_wr_block` are all low.
- R2: A frame of start, device byte A0h, word byte 01h, data byte 00h and then stop, with `hv_present` high from before the start through the stop, drives `set_req` high for exactly the stop cycle. `prog_busy` is high from the next cycle on.
- R3: A set request loads `vcc_code` into `trip_code` only when `vcc_code` is greater than the stored code. Otherwise `trip_code` keeps its value. `trip_code` changes only on a set or clear request.
- R4: The same frame with word byte 03h drives `clr_req` for the stop cycle. On the next cycle `trip_code` equals `FLOOR_CODE` (4 by default).
- R5: If `hv_present` is low in the cycle of the start event, the frame is discarded, even if the flag rises later in the frame.
- R6: If `hv_present` goes low at any point between the start and the stop, the frame is discarded.
- R7: A device byte other than A0h, a word byte other than 01h or 03h, or a data byte other than 00h discards the frame.
- R8: A stop that arrives before the data byte has been acknowledged discards the frame. So does a fourth byte after the data byte.
- R9: `prog_busy` stays high while `hv_present` is high. In the first cycle with `hv_present` low it raises `prog_done` for one cycle, and `prog_busy` is low from the next cycle.
- R10: While `prog_busy` is high, start, byte and stop events are ignored. A complete command frame sent during that time produces no request.
- R11: `nvm_wr_block` is high in the stop cycle of a qualifying frame and throughout `prog_busy`. It is low at the stop of any discarded frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_start | input | 1 | One-cycle strobe: start condition seen |
| bus_stop | input | 1 | One-cycle strobe: stop condition seen |
| rx_valid | input | 1 | One-cycle strobe: a byte was received and acknowledged |
| rx_byte | input | 8 | Byte value, valid with `rx_valid` |
| hv_present | input | 1 | Programming voltage present on the write-protect pin |
| vcc_code | input | CODE_W | Present supply level as a code, captured by a set |
| trip_code | output | CODE_W | Stored trip-threshold code |
| prog_busy | output | 1 | Operation in progress, waiting for the flag to drop |
| prog_done | output | 1 | One-cycle pulse when the operation completes |
| set_req | output | 1 | Set request to the threshold cell, in the stop cycle |
| clr_req | output | 1 | Clear request to the threshold cell, in the stop cycle |
| nvm_wr_block | output | 1 | Suppresses the normal memory-write path |

## Verification
The properties assume that the bus decoder never raises start and stop in the same cycle. They also assume that a byte strobe never coincides with either event, and that `vcc_code` only matters in the cycle of a set request. The bench keeps to these assumptions by giving each event its own cycle, with an idle cycle between events, and by holding `vcc_code` steady across each frame. The flag is changed only on falling edges, at chosen points of a frame. This lets each discard rule be exercised alone.

// File: rtl/tpd_pkg.sv
package tpd_pkg;

    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] DEV_SEL  = 8'hA0;
    localparam logic [BYTE_W-1:0] WA_SET   = 8'h01;
    localparam logic [BYTE_W-1:0] WA_CLR   = 8'h03;
    localparam logic [BYTE_W-1:0] DATA_KEY = 8'h00;

    typedef enum logic [2:0] {
        FR_IDLE,
        FR_DEV,
        FR_WADDR,
        FR_DATA,
        FR_END,
        FR_TAIL
    } frame_st_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_SET,
        OP_CLR
    } op_kind_e;

    typedef struct packed {
        logic set;
        logic clr;
    } op_req_t;

    function automatic op_kind_e decode_waddr(input logic [BYTE_W-1:0] b);
        op_kind_e k;
        case (b)
            WA_SET:  k = OP_SET;
            WA_CLR:  k = OP_CLR;
            default: k = OP_NONE;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/tpd_frame.sv
module tpd_frame
    import tpd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              hv_present,
    input  logic              busy_i,
    output op_req_t           req_o,
    output logic              cand_o
);

    frame_st_e st;
    logic      qual;
    op_kind_e  kind;
    logic      issue;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= FR_IDLE;
            qual <= 1'b0;
            kind <= OP_NONE;
        end else if (busy_i) begin
            st   <= FR_IDLE;
            qual <= 1'b0;
        end else if (bus_start) begin
            st   <= FR_DEV;
            qual <= hv_present;
            kind <= OP_NONE;
        end else if (bus_stop) begin
            st   <= FR_IDLE;
            qual <= 1'b0;
        end else begin
            if (rx_valid) begin
                case (st)
                    FR_DEV: begin
                        qual <= qual && (rx_byte == DEV_SEL);
                        st   <= FR_WADDR;
                    end
                    FR_WADDR: begin
                        kind <= decode_waddr(rx_byte);
                        st   <= FR_DATA;
                    end
                    FR_DATA: begin
                        qual <= qual && (rx_byte == DATA_KEY);
                        st   <= FR_END;
                    end
                    FR_END: begin
                        qual <= 1'b0;
                        st   <= FR_TAIL;
                    end
                    default: ;
                endcase
            end
            if (!hv_present) begin
                qual <= 1'b0;
            end
        end
    end

    always_comb begin
        cand_o    = (st == FR_END) && qual && hv_present && (kind != OP_NONE);
        issue     = cand_o && bus_stop && !bus_start && !busy_i;
        req_o.set = issue && (kind == OP_SET);
        req_o.clr = issue && (kind == OP_CLR);
    end

endmodule

// File: rtl/tpd_hold.sv
module tpd_hold (
    input  logic clk,
    input  logic rst,
    input  logic issue_i,
    input  logic hv_present,
    output logic busy_o,
    output logic done_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_o <= 1'b0;
        end else if (issue_i) begin
            busy_o <= 1'b1;
        end else if (busy_o && !hv_present) begin
            busy_o <= 1'b0;
        end
    end

    assign done_o = busy_o && !hv_present;

endmodule

// File: rtl/tpd_cell.sv
module tpd_cell
    import tpd_pkg::*;
#(
    parameter int CODE_W       = 6,
    parameter int DEFAULT_CODE = 20,
    parameter int FLOOR_CODE   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  op_req_t           req_i,
    input  logic [CODE_W-1:0] vcc_code,
    output logic [CODE_W-1:0] trip_o
);

    localparam logic [CODE_W-1:0] RST_VAL = CODE_W'(DEFAULT_CODE);
    localparam logic [CODE_W-1:0] LOW_VAL = CODE_W'(FLOOR_CODE);

    always_ff @(posedge clk) begin
        if (rst) begin
            trip_o <= RST_VAL;
        end else if (req_i.clr) begin
            trip_o <= LOW_VAL;
        end else if (req_i.set && (vcc_code > trip_o)) begin
            trip_o <= vcc_code;
        end
    end

endmodule

// File: rtl/trip_prog_detect.sv
module trip_prog_detect
    import tpd_pkg::*;
#(
    parameter int CODE_W       = 6,
    parameter int DEFAULT_CODE = 20,
    parameter int FLOOR_CODE   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic              hv_present,
    input  logic [CODE_W-1:0] vcc_code,
    output logic [CODE_W-1:0] trip_code,
    output logic              prog_busy,
    output logic              prog_done,
    output logic              set_req,
    output logic              clr_req,
    output logic              nvm_wr_block
);

    op_req_t req;
    logic    cand;

    tpd_frame u_frame (
        .clk       (clk),
        .rst       (rst),
        .bus_start (bus_start),
        .bus_stop  (bus_stop),
        .rx_valid  (rx_valid),
        .rx_byte   (rx_byte),
        .hv_present(hv_present),
        .busy_i    (prog_busy),
        .req_o     (req),
        .cand_o    (cand)
    );

    tpd_hold u_hold (
        .clk       (clk),
        .rst       (rst),
        .issue_i   (req.set || req.clr),
        .hv_present(hv_present),
        .busy_o    (prog_busy),
        .done_o    (prog_done)
    );

    tpd_cell #(
        .CODE_W      (CODE_W),
        .DEFAULT_CODE(DEFAULT_CODE),
        .FLOOR_CODE  (FLOOR_CODE)
    ) u_cell (
        .clk     (clk),
        .rst     (rst),
        .req_i   (req),
        .vcc_code(vcc_code),
        .trip_o  (trip_code)
    );

    assign set_req      = req.set;
    assign clr_req      = req.clr;
    assign nvm_wr_block = cand || prog_busy;

endmodule

// File: rtl/tpd_checker.sv
module tpd_checker #(
    parameter int CODE_W     = 6,
    parameter int FLOOR_CODE = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              hv_present,
    input logic [CODE_W-1:0] vcc_code,
    input logic [CODE_W-1:0] trip_code,
    input logic              prog_busy,
    input logic              prog_done,
    input logic              set_req,
    input logic              clr_req,
    input logic              nvm_wr_block
);

    // R2
    req_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({set_req, clr_req}));

    // R2
    busy_after_req_chk: assert property (@(posedge clk) disable iff (rst)
        (set_req || clr_req) |=> prog_busy);

    // R3
    set_monotone_chk: assert property (@(posedge clk) disable iff (rst)
        set_req |=> (trip_code >= $past(trip_code)) && (trip_code >= $past(vcc_code)));

    // R3
    code_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!set_req && !clr_req) |=> $stable(trip_code));

    // R4
    clear_floor_chk: assert property (@(posedge clk) disable iff (rst)
        clr_req |=> (trip_code == CODE_W'(FLOOR_CODE)));

    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (prog_busy && hv_present) |=> prog_busy);

    // R9
    done_exit_chk: assert property (@(posedge clk) disable iff (rst)
        prog_done |=> !prog_busy);

    // R10
    no_req_busy_chk: assert property (@(posedge clk) disable iff (rst)
        prog_busy |-> !(set_req || clr_req));

    // R11
    block_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (prog_busy || set_req || clr_req) |-> nvm_wr_block);

endmodule

bind trip_prog_detect tpd_checker #(
    .CODE_W    (CODE_W),
    .FLOOR_CODE(FLOOR_CODE)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .hv_present  (hv_present),
    .vcc_code    (vcc_code),
    .trip_code   (trip_code),
    .prog_busy   (prog_busy),
    .prog_done   (prog_done),
    .set_req     (set_req),
    .clr_req     (clr_req),
    .nvm_wr_block(nvm_wr_block)
);

// File: tb/sim_trip_prog_detect.sv
`timescale 1ns/1ps
module sim_trip_prog_detect;

    localparam int CW = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_start = 1'b0;
    logic          bus_stop = 1'b0;
    logic          rx_valid = 1'b0;
    logic [7:0]    rx_byte = 8'h00;
    logic          hv_present = 1'b0;
    logic [CW-1:0] vcc_code = '0;
    logic [CW-1:0] trip_code;
    logic          prog_busy, prog_done, set_req, clr_req, nvm_wr_block;

    int n_chk = 0;
    int n_err = 0;
    int exp_trip = 20;
    bit finished = 0;

    always #10 clk = ~clk;

    trip_prog_detect u0 (
        .clk(clk), .rst(rst), .bus_start(bus_start), .bus_stop(bus_stop),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .hv_present(hv_present),
        .vcc_code(vcc_code), .trip_code(trip_code), .prog_busy(prog_busy),
        .prog_done(prog_done), .set_req(set_req), .clr_req(clr_req),
        .nvm_wr_block(nvm_wr_block)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick_start();
        @(negedge clk); bus_start = 1'b1;
        @(negedge clk); bus_start = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk); rx_valid = 1'b1; rx_byte = b;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic send_frame(input logic [7:0] d, input logic [7:0] w, input logic [7:0] v);
        tick_start();
        send_byte(d);
        send_byte(w);
        send_byte(v);
    endtask

    // drives a stop, checks the stop-cycle outputs, then the registered ones
    task automatic stop_expect(input string req, input int es, input int ec, input int eb);
        @(negedge clk); bus_stop = 1'b1;
        #1;
        check({req, " set_req"}, set_req, es);
        check({req, " clr_req"}, clr_req, ec);
        check({req, " nvm_wr_block"}, nvm_wr_block, eb);
        @(negedge clk); bus_stop = 1'b0;
        check({req, " busy after stop"}, prog_busy, es | ec);
        check({req, " trip_code"}, trip_code, exp_trip);
    endtask

    task automatic release_hv(input string req);
        @(negedge clk); hv_present = 1'b0;
        #1 check({req, " done pulse"}, prog_done, 1);
        @(negedge clk);
        check({req, " busy cleared"}, prog_busy, 0);
        check({req, " block cleared"}, nvm_wr_block, 0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 trip_code", trip_code, 20);
        check("R1 busy", prog_busy, 0);
        check("R1 done", prog_done, 0);
        check("R1 block", nvm_wr_block, 0);
        check("R1 reqs", {set_req, clr_req}, 0);
    endtask

    task automatic t_set_raise();
        vcc_code = 6'd30;
        @(negedge clk); hv_present = 1'b1;
        send_frame(8'hA0, 8'h01, 8'h00);
        exp_trip = 30;
        stop_expect("R2 R3 R11 set", 1, 0, 1);
        repeat (4) @(negedge clk);
        check("R9 busy held while flag high", prog_busy, 1);
        check("R11 block held while busy", nvm_wr_block, 1);
        release_hv("R9");
    endtask

    task automatic t_set_lower();
        vcc_code = 6'd10;
        @(negedge clk); hv_present = 1'b1;
        send_frame(8'hA0, 8'h01, 8'h00);
        stop_expect("R3 set below stored", 1, 0, 1);
        release_hv("R3");
    endtask

    task automatic t_clear();
        @(negedge clk); hv_present = 1'b1;
        send_frame(8'hA0, 8'h03, 8'h00);
        exp_trip = 4;
        stop_expect("R4 clear", 0, 1, 1);
        release_hv("R4");
        vcc_code = 6'd12;
        @(negedge clk); hv_present = 1'b1;
        send_frame(8'hA0, 8'h01, 8'h00);
        exp_trip = 12;
        stop_expect("R3 set after clear", 1, 0, 1);
        release_hv("R3");
    endtask

    task automatic t_late_flag();
        vcc_code = 6'd50;
        @(negedge clk); hv_present = 1'b0;
        tick_start();
        hv_present = 1'b1;
        send_byte(8'hA0);
        send_byte(8'h01);
        send_byte(8'h00);
        stop_expect("R5 flag late", 0, 0, 0);
        hv_present = 1'b0;
    endtask

    task automatic t_early_drop();
        vcc_code = 6'd50;
        @(negedge clk); hv_present = 1'b1;
        send_frame(8'hA0, 8'h01, 8'h00);
        hv_present = 1'b0;
        @(negedge clk); hv_present = 1'b1;
        stop_expect("R6 flag dropped", 0, 0, 0);
        hv_present = 1'b0;
    endtask

    task automatic t_mismatch();
        vcc_code = 6'd50;
        @(negedge clk); hv_present = 1'b1;
        send_frame(8'hA2, 8'h01, 8'h00);
        stop_expect("R7 R11 device byte", 0, 0, 0);
        send_frame(8'hA0, 8'h02, 8'h00);
        stop_expect("R7 R11 word byte", 0, 0, 0);
        send_frame(8'hA0, 8'h03, 8'h01);
        stop_expect("R7 R11 data byte", 0, 0, 0);
        hv_present = 1'b0;
    endtask

    task automatic t_length();
        vcc_code = 6'd50;
        @(negedge clk); hv_present = 1'b1;
        tick_start();
        send_byte(8'hA0);
        send_byte(8'h01);
        stop_expect("R8 short frame", 0, 0, 0);
        send_frame(8'hA0, 8'h01, 8'h00);
        send_byte(8'h00);
        stop_expect("R8 extra byte", 0, 0, 0);
        hv_present = 1'b0;
    endtask

    task automatic t_busy_ignore();
        vcc_code = 6'd40;
        @(negedge clk); hv_present = 1'b1;
        send_frame(8'hA0, 8'h01, 8'h00);
        exp_trip = 40;
        stop_expect("R2 set", 1, 0, 1);
        send_frame(8'hA0, 8'h03, 8'h00);
        @(negedge clk); bus_stop = 1'b1;
        #1 check("R10 clr ignored while busy", clr_req, 0);
        @(negedge clk); bus_stop = 1'b0;
        check("R10 trip unchanged", trip_code, exp_trip);
        check("R10 still busy", prog_busy, 1);
        release_hv("R10");
    endtask

    initial begin
        t_reset();
        t_set_raise();
        t_set_lower();
        t_clear();
        t_late_flag();
        t_early_drop();
        t_mismatch();
        t_length();
        t_busy_ignore();
        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule